// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register File

This block sits between a byte-wide host bus and a real-time clock's calendar counter. The bus has two locations. A write to the even location (address bit low) selects one of up to 128 register slots. The odd location then reads or writes the selected slot. The slots hold the displayed time fields, three alarm bytes, two control registers (A and B), a status register (C) and a fixed validity register (D). The remaining slots are plain storage bytes.

Once per second the block runs an update. The second tick raises the update-in-progress flag. After eight ticks of the 32.768 kHz reference, the block copies the calendar counter's binary time into the time registers in the format the host has chosen, checks the alarm and posts the status flags. It then drops the flag. A set mode stops these copies. When the host leaves set mode, or writes a time field while not in set mode, the block pulses a load strobe so that the counter takes the register contents. Calendar arithmetic and periodic-rate division are done outside the block.

Top module: `rtc_regfile`

Slot map (the host software decodes these): 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 weekday, 7 day of month, 8 month, 9 year, 10 A, 11 B, 12 C, 13 D.

## Requirements
- R1: A write with `addr_i`=0 sets the index to `wdata_i[6:0]` and drops bit 7. A read with `addr_i`=0 returns 0xFF. With `addr_i`=1, an index at or above `DEPTH` reads 0xFF and ignores writes.
- R2: Bit 7 of A is update-in-progress. A host write to A stores bits 6..0 and leaves bit 7 as it was.
- R3: After reset, A=0x26, B=0x02, C=0x00 and D=0x80. Writes to C and D change nothing.
- R4: A read of C returns its value, then clears C to 0x00. `irq_o` equals C bit 7, so the same read also drops `irq_o`.
- R5: B bit 7 is SET, and `set_mode_o` follows it. Writing B with SET=1 clears update-in-progress. While SET is 1, no tick raises update-in-progress and no update copies time into registers 0,2,4,6,7,8,9.
- R6: One cycle after a write that changes SET from 1 to 0, or after a write to a time register while SET is 0, `load_o` is high for one cycle. `load_time_o` then holds registers 9,8,7,6,4,2,0, most significant byte first.
- R7: When A bits 6..4 equal 010 and SET is 0, `tick_sec_i` sets update-in-progress. At the eighth `tick_32k_i` edge after it, the time registers take the calendar values and update-in-progress clears.
- R8: B bit 2 = 1 stores fields in binary; 0 stores them in BCD. B bit 1 = 1 stores the hour as 0..23. B bit 1 = 0 stores hour mod 12, with bit 7 set when the hour is 12 or more.
- R9: An alarm byte matches when its bits 7..6 are both 1, or when its value, decoded in the B bit 2 format, equals the calendar second, minute or 0..23 hour. When all three match at update completion and B bit 5 is 1, C gets 0xA0 ORed in.
- R10: At update completion with B bit 4 = 1 and SET = 0, C gets 0x90 ORed in.
- R11: When A bits 6..4 are not 010, `tick_sec_i` is ignored: update-in-progress stays low and the time registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 = index location, 1 = data location |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (its side effect acts on C) |
| rdata_o | output | 8 | Read data, combinational |
| tick_sec_i | input | 1 | Once-per-second pulse |
| tick_32k_i | input | 1 | 32.768 kHz reference pulse |
| cal_sec_i | input | 6 | Counter seconds, binary |
| cal_min_i | input | 6 | Counter minutes, binary |
| cal_hour_i | input | 5 | Counter hour 0..23, binary |
| cal_wday_i | input | 3 | Counter weekday, binary |
| cal_mday_i | input | 5 | Counter day of month, binary |
| cal_mon_i | input | 4 | Counter month 1..12, binary |
| cal_year_i | input | 7 | Counter year 0..99, binary |
| irq_o | output | 1 | Interrupt request |
| set_mode_o | output | 1 | SET bit of B |
| load_o | output | 1 | Strobe that loads the counter from the registers |
| load_time_o | output | 56 | Time register bytes for the load |

## Verification
The bench builds the block with its default `DEPTH` of 64 and `UPD_DLY` of 8. With a depth of 64, indices 64 to 127 have no storage behind them, so the bench can check the out-of-range read and write behaviour. With a delay of 8 reference ticks, the bench can sample update-in-progress after the seventh tick and after the eighth. Random calendar values, formats and alarm bytes (some wildcarded, some exact matches, some misses) go through full update cycles. Directed cases cover set mode, a stopped divider and writes to the read-only bit.

// File: rtl/rtc_regfile_pkg.sv
`timescale 1ns/1ps
package rtc_regfile_pkg;
  localparam logic [6:0] IX_SEC  = 7'd0;
  localparam logic [6:0] IX_ASEC = 7'd1;
  localparam logic [6:0] IX_MIN  = 7'd2;
  localparam logic [6:0] IX_AMIN = 7'd3;
  localparam logic [6:0] IX_HR   = 7'd4;
  localparam logic [6:0] IX_AHR  = 7'd5;
  localparam logic [6:0] IX_WDAY = 7'd6;
  localparam logic [6:0] IX_MDAY = 7'd7;
  localparam logic [6:0] IX_MON  = 7'd8;
  localparam logic [6:0] IX_YEAR = 7'd9;
  localparam logic [6:0] IX_A    = 7'd10;
  localparam logic [6:0] IX_B    = 7'd11;
  localparam logic [6:0] IX_C    = 7'd12;
  localparam logic [6:0] IX_D    = 7'd13;

  localparam logic [7:0] A_RST = 8'h26;
  localparam logic [7:0] B_RST = 8'h02;
  localparam logic [7:0] D_RST = 8'h80;
  localparam logic [2:0] DIV_RUN = 3'b010;

  typedef enum logic [2:0] {
    B_H24 = 3'd1, B_BIN = 3'd2, B_UIE = 3'd4, B_AIE = 3'd5, B_SET = 3'd7
  } b_bit_e;

  function automatic logic [7:0] fmt_field(input logic [6:0] v, input logic bin);
    logic [6:0] tens, ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] unfmt_field(input logic [7:0] b, input logic bin);
    return bin ? b : ({4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]});
  endfunction
endpackage

// File: rtl/rtc_upd_seq.sv
`timescale 1ns/1ps
module rtc_upd_seq #(
  parameter int unsigned UPD_DLY = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_sec_i,
  input  logic tick_32k_i,
  input  logic run_ok_i,
  input  logic hold_i,
  output logic uip_set_o,
  output logic done_o
);
  localparam int unsigned CW = (UPD_DLY < 2) ? 1 : $clog2(UPD_DLY);
  localparam logic [CW-1:0] LAST = CW'(UPD_DLY - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          start;

  assign start     = !busy_q && tick_sec_i && run_ok_i;
  assign uip_set_o = start && !hold_i;
  assign done_o    = busy_q && tick_32k_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q && tick_32k_i) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
`timescale 1ns/1ps
module rtc_alarm_cmp #(
  parameter int unsigned NF = 3
) (
  input  logic [NF-1:0][7:0] alarm_i,
  input  logic [NF-1:0][6:0] cur_i,
  input  logic               bin_i,
  output logic               hit_o
);
  import rtc_regfile_pkg::*;
  logic [NF-1:0] fld_hit;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign fld_hit[g] = (alarm_i[g][7:6] == 2'b11) ||
                        (unfmt_field(alarm_i[g], bin_i) == {1'b0, cur_i[g]});
  end

  assign hit_o = &fld_hit;
endmodule

// File: rtl/rtc_time_fmt.sv
`timescale 1ns/1ps
module rtc_time_fmt (
  input  logic [5:0]      sec_i,
  input  logic [5:0]      min_i,
  input  logic [4:0]      hour_i,
  input  logic [2:0]      wday_i,
  input  logic [4:0]      mday_i,
  input  logic [3:0]      mon_i,
  input  logic [6:0]      year_i,
  input  logic            bin_i,
  input  logic            h24_i,
  output logic [6:0][7:0] fld_o
);
  import rtc_regfile_pkg::*;
  logic       pm;
  logic [6:0] h12;

  assign pm  = hour_i >= 5'd12;
  assign h12 = pm ? {2'b0, hour_i - 5'd12} : {2'b0, hour_i};

  // fld_o order: sec, min, hour, wday, mday, mon, year
  assign fld_o[0] = fmt_field({1'b0, sec_i}, bin_i);
  assign fld_o[1] = fmt_field({1'b0, min_i}, bin_i);
  assign fld_o[2] = h24_i ? fmt_field({2'b0, hour_i}, bin_i)
                          : (fmt_field(h12, bin_i) | {pm, 7'd0});
  assign fld_o[3] = fmt_field({4'b0, wday_i}, bin_i);
  assign fld_o[4] = fmt_field({2'b0, mday_i}, bin_i);
  assign fld_o[5] = fmt_field({3'b0, mon_i}, bin_i);
  assign fld_o[6] = fmt_field(year_i, bin_i);
endmodule

// File: rtl/rtc_regfile.sv
`timescale 1ns/1ps
module rtc_regfile #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned UPD_DLY = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        wr_i,
  input  logic        rd_i,
  output logic [7:0]  rdata_o,
  input  logic        tick_sec_i,
  input  logic        tick_32k_i,
  input  logic [5:0]  cal_sec_i,
  input  logic [5:0]  cal_min_i,
  input  logic [4:0]  cal_hour_i,
  input  logic [2:0]  cal_wday_i,
  input  logic [4:0]  cal_mday_i,
  input  logic [3:0]  cal_mon_i,
  input  logic [6:0]  cal_year_i,
  output logic        irq_o,
  output logic        set_mode_o,
  output logic        load_o,
  output logic [55:0] load_time_o
);
  import rtc_regfile_pkg::*;
  localparam int unsigned AW = (DEPTH < 16) ? 4 : $clog2(DEPTH);
  localparam logic [6:0] TIME_IX [7] = '{IX_SEC, IX_MIN, IX_HR, IX_WDAY, IX_MDAY, IX_MON, IX_YEAR};

  logic [7:0]      mem [DEPTH];
  logic [6:0]      idx_q;
  logic            load_q;
  logic            idx_ok, data_wr, rd_c, wr_a;
  logic            uip_set, upd_done, alarm_hit, uip_nxt;
  logic [7:0]      reg_a, reg_b, reg_c, reg_d, c_nxt;
  logic [6:0][7:0] tfld;

  assign reg_a = mem[AW'(IX_A)];
  assign reg_b = mem[AW'(IX_B)];
  assign reg_c = mem[AW'(IX_C)];
  assign reg_d = mem[AW'(IX_D)];

  assign idx_ok  = 32'(idx_q) < DEPTH;
  assign data_wr = wr_i && addr_i && idx_ok;
  assign wr_a    = data_wr && (idx_q == IX_A);
  assign rd_c    = rd_i && addr_i && (idx_q == IX_C);

  rtc_upd_seq #(.UPD_DLY(UPD_DLY)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_sec_i(tick_sec_i), .tick_32k_i(tick_32k_i),
    .run_ok_i(reg_a[6:4] == DIV_RUN), .hold_i(reg_b[B_SET]),
    .uip_set_o(uip_set), .done_o(upd_done)
  );

  rtc_alarm_cmp #(.NF(3)) u_alarm (
    .alarm_i({mem[AW'(IX_AHR)], mem[AW'(IX_AMIN)], mem[AW'(IX_ASEC)]}),
    .cur_i({{2'b0, cal_hour_i}, {1'b0, cal_min_i}, {1'b0, cal_sec_i}}),
    .bin_i(reg_b[B_BIN]), .hit_o(alarm_hit)
  );

  rtc_time_fmt u_fmt (
    .sec_i(cal_sec_i), .min_i(cal_min_i), .hour_i(cal_hour_i), .wday_i(cal_wday_i),
    .mday_i(cal_mday_i), .mon_i(cal_mon_i), .year_i(cal_year_i),
    .bin_i(reg_b[B_BIN]), .h24_i(reg_b[B_H24]), .fld_o(tfld)
  );

  always_comb begin
    uip_nxt = reg_a[7];
    if (uip_set)  uip_nxt = 1'b1;
    if (upd_done) uip_nxt = 1'b0;
    if (data_wr && idx_q == IX_B && wdata_i[B_SET]) uip_nxt = 1'b0;
  end

  // flags posted in the same cycle as a clearing read survive
  always_comb begin
    c_nxt = rd_c ? 8'h00 : reg_c;
    if (upd_done && reg_b[B_AIE] && alarm_hit)          c_nxt = c_nxt | 8'hA0;
    if (upd_done && reg_b[B_UIE] && !reg_b[B_SET])      c_nxt = c_nxt | 8'h90;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      mem[AW'(IX_A)] <= A_RST;
      mem[AW'(IX_B)] <= B_RST;
      mem[AW'(IX_D)] <= D_RST;
      idx_q  <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (wr_i && !addr_i) idx_q <= wdata_i[6:0];
      if (upd_done && !reg_b[B_SET]) begin
        for (int f = 0; f < 7; f++) mem[AW'(TIME_IX[f])] <= tfld[f];
      end
      mem[AW'(IX_A)] <= {uip_nxt, wr_a ? wdata_i[6:0] : reg_a[6:0]};
      mem[AW'(IX_C)] <= c_nxt;
      if (data_wr) begin
        unique case (idx_q)
          IX_A, IX_C, IX_D: ;
          IX_B: begin
            mem[AW'(IX_B)] <= wdata_i;
            if (!wdata_i[B_SET] && reg_b[B_SET]) load_q <= 1'b1;
          end
          IX_SEC, IX_MIN, IX_HR, IX_WDAY, IX_MDAY, IX_MON, IX_YEAR: begin
            mem[idx_q[AW-1:0]] <= wdata_i;
            if (!reg_b[B_SET]) load_q <= 1'b1;
          end
          default: mem[idx_q[AW-1:0]] <= wdata_i;
        endcase
      end
    end
  end

  assign rdata_o     = !addr_i ? 8'hFF : (idx_ok ? mem[idx_q[AW-1:0]] : 8'hFF);
  assign irq_o       = reg_c[7];
  assign set_mode_o  = reg_b[B_SET];
  assign load_o      = load_q;
  assign load_time_o = {mem[AW'(IX_YEAR)], mem[AW'(IX_MON)], mem[AW'(IX_MDAY)],
                        mem[AW'(IX_WDAY)], mem[AW'(IX_HR)], mem[AW'(IX_MIN)],
                        mem[AW'(IX_SEC)]};
endmodule

// File: rtl/rtc_regfile_chk.sv
`timescale 1ns/1ps
module rtc_regfile_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic       set_mode_o,
  input logic [7:0] reg_a,
  input logic [7:0] reg_c,
  input logic [7:0] reg_d,
  input logic [6:0] idx,
  input logic       uip_set,
  input logic       upd_done
);
  logic wr_a_chk, rd_c_chk;
  assign wr_a_chk = wr_i && addr_i && idx == 7'd10;
  assign rd_c_chk = rd_i && addr_i && idx == 7'd12;

  a_r1_index_reads_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i |-> rdata_o == 8'hFF);
  a_r2_uip_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a_chk && !uip_set && !upd_done) |=> reg_a[7] == $past(reg_a[7]));
  a_r3_d_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(reg_d));
  a_r4_c_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_c_chk && !upd_done) |=> reg_c == 8'h00);
  a_r5_set_no_uip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_mode_o |-> !reg_a[7]);
  a_r10_irq_from_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(upd_done));
endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .set_mode_o(set_mode_o),
  .reg_a(reg_a), .reg_c(reg_c), .reg_d(reg_d), .idx(idx_q),
  .uip_set(uip_set), .upd_done(upd_done)
);

// File: tb/rtc_regfile_test.sv
`timescale 1ns/1ps
module rtc_regfile_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic addr = 1'b0, wr = 1'b0, rd = 1'b0, tsec = 1'b0, t32 = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [5:0] c_sec = '0, c_min = '0;
  logic [4:0] c_hr = '0, c_mday = 5'd1;
  logic [2:0] c_wday = '0;
  logic [3:0] c_mon = 4'd1;
  logic [6:0] c_year = '0;
  logic irq, setm, ld;
  logic [55:0] ld_time;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  rtc_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .tick_sec_i(tsec), .tick_32k_i(t32),
    .cal_sec_i(c_sec), .cal_min_i(c_min), .cal_hour_i(c_hr), .cal_wday_i(c_wday),
    .cal_mday_i(c_mday), .cal_mon_i(c_mon), .cal_year_i(c_year),
    .irq_o(irq), .set_mode_o(setm), .load_o(ld), .load_time_o(ld_time)
  );

  function automatic logic [7:0] enc(input int v, input bit bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int dec(input logic [7:0] b, input bit bin);
    return bin ? int'(b) : int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] enc_hr(input int h, input bit bin, input bit h24);
    if (h24) return enc(h, bin);
    return enc(h % 12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction
  function automatic bit amatch(input logic [7:0] a, input int cur, input bit bin);
    return (a[7:6] == 2'b11) || (dec(a, bin) == cur);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask
  task automatic reg_wr(input logic [6:0] ix, input logic [7:0] d);
    bus_wr(1'b0, {1'b0, ix}); bus_wr(1'b1, d);
  endtask
  task automatic reg_rd(input logic [6:0] ix, output logic [7:0] v);
    bus_wr(1'b0, {1'b0, ix});
    @(negedge clk); addr = 1'b1; rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask
  task automatic sec_tick();
    @(negedge clk); tsec = 1'b1; @(negedge clk); tsec = 1'b0;
  endtask
  task automatic ref_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); t32 = 1'b1; @(negedge clk); t32 = 1'b0;
    end
  endtask

  initial begin : watchdog
    #1200000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic [6:0] tix [7];
    void'($urandom(32'd4242));
    tix = '{7'd0, 7'd2, 7'd4, 7'd6, 7'd7, 7'd8, 7'd9};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    reg_rd(7'd10, v); chk("R3 reset A", v, 8'h26);
    reg_rd(7'd11, v); chk("R3 reset B", v, 8'h02);
    reg_rd(7'd12, v); chk("R3 reset C", v, 8'h00);
    reg_rd(7'd13, v); chk("R3 reset D", v, 8'h80);
    chk("R5 set_mode reset", {7'd0, setm}, 8'h00);

    // R1 index masking, even read, out of range
    bus_wr(1'b0, 8'h8A);
    @(negedge clk); addr = 1'b1; #1 chk("R1 masked index", rdata, 8'h26);
    addr = 1'b0; #1 chk("R1 even read", rdata, 8'hFF);
    reg_wr(7'd70, 8'h12);
    reg_rd(7'd70, v); chk("R1 out of range", v, 8'hFF);
    reg_wr(7'd20, 8'h5A);
    reg_rd(7'd20, v); chk("R1 plain slot", v, 8'h5A);

    // R3 C and D ignore writes
    reg_wr(7'd12, 8'hFF); reg_rd(7'd12, v); chk("R3 C write", v, 8'h00);
    reg_wr(7'd13, 8'h00); reg_rd(7'd13, v); chk("R3 D write", v, 8'h80);

    // R2 write to A keeps UIP (low)
    reg_wr(7'd10, 8'hA6); reg_rd(7'd10, v); chk("R2 uip kept low", v, 8'h26);
    // R7 raise UIP, R2 keep it high across a write
    sec_tick();
    reg_rd(7'd10, v); chk("R7 uip raised", v, 8'hA6);
    reg_wr(7'd10, 8'h26); reg_rd(7'd10, v); chk("R2 uip kept high", v, 8'hA6);
    ref_ticks(7);
    reg_rd(7'd10, v); chk("R7 uip after 7 ticks", v, 8'hA6);
    ref_ticks(1);
    reg_rd(7'd10, v); chk("R7 uip cleared", v, 8'h26);

    // R5 SET clears UIP and blocks updates
    c_sec = 6'd33;
    sec_tick();
    reg_wr(7'd11, 8'h82);
    reg_rd(7'd10, v); chk("R5 set clears uip", v, 8'h26);
    chk("R5 set_mode out", {7'd0, setm}, 8'h01);
    ref_ticks(8);
    reg_wr(7'd0, 8'h11);
    chk("R6 no load in set", {7'd0, ld}, 8'h00);
    sec_tick();
    reg_rd(7'd10, v); chk("R5 no uip in set", v, 8'h26);
    ref_ticks(8);
    reg_rd(7'd0, v); chk("R5 no copy in set", v, 8'h11);
    // R6 leaving set mode loads
    bus_wr(1'b0, 8'd11); bus_wr(1'b1, 8'h02);
    chk("R6 load on set exit", {7'd0, ld}, 8'h01);
    chk("R6 load bytes", ld_time[7:0], 8'h11);
    bus_wr(1'b0, 8'd2); bus_wr(1'b1, 8'h42);
    chk("R6 load on time write", {7'd0, ld}, 8'h01);
    chk("R6 load minute byte", ld_time[15:8], 8'h42);

    // R11 divider stopped
    reg_wr(7'd10, 8'h06);
    sec_tick();
    reg_rd(7'd10, v); chk("R11 no uip", v, 8'h06);
    ref_ticks(8);
    reg_rd(7'd0, v); chk("R11 no copy", v, 8'h11);
    reg_wr(7'd10, 8'h26);

    // random update cycles: R7 R8 R9 R10 R4
    for (int it = 0; it < 40; it++) begin
      bit bin, h24, aie, uie, hit;
      int cs, cm, ch;
      logic [7:0] al [3];
      logic [7:0] exp_c, bb;
      logic [7:0] exp_t [7];
      bin = 1'($urandom); h24 = 1'($urandom); aie = 1'($urandom); uie = 1'($urandom);
      cs = $urandom_range(59); cm = $urandom_range(59); ch = $urandom_range(23);
      c_sec = 6'(cs); c_min = 6'(cm); c_hr = 5'(ch);
      c_wday = 3'($urandom_range(6)); c_mday = 5'($urandom_range(31, 1));
      c_mon = 4'($urandom_range(12, 1)); c_year = 7'($urandom_range(99));
      for (int k = 0; k < 3; k++) begin
        int cur, sel;
        cur = (k == 0) ? cs : (k == 1) ? cm : ch;
        sel = $urandom_range(3);
        if (sel == 0)      al[k] = 8'hC0 | 8'($urandom_range(63));
        else if (sel == 3) al[k] = enc((cur + 1) % 24, bin);
        else               al[k] = enc(cur, bin);
      end
      bb = {2'b00, aie, uie, 1'b0, bin, h24, 1'b0};
      reg_wr(7'd11, bb);
      reg_wr(7'd1, al[0]); reg_wr(7'd3, al[1]); reg_wr(7'd5, al[2]);
      reg_rd(7'd12, v);
      hit = amatch(al[0], cs, bin) && amatch(al[1], cm, bin) && amatch(al[2], ch, bin);
      exp_c = ((aie && hit) ? 8'hA0 : 8'h00) | (uie ? 8'h90 : 8'h00);
      exp_t = '{enc(cs, bin), enc(cm, bin), enc_hr(ch, bin, h24), enc(int'(c_wday), bin),
                enc(int'(c_mday), bin), enc(int'(c_mon), bin), enc(int'(c_year), bin)};
      sec_tick();
      reg_rd(7'd10, v); chk("R7 uip raised rnd", v, 8'hA6);
      ref_ticks(8);
      chk("R4 irq level", {7'd0, irq}, {7'd0, exp_c[7]});
      reg_rd(7'd12, v); chk("R9 R10 flags", v, exp_c);
      chk("R4 irq dropped", {7'd0, irq}, 8'h00);
      reg_rd(7'd12, v); chk("R4 C cleared", v, 8'h00);
      for (int f = 0; f < 7; f++) begin
        reg_rd(tix[f], v);
        chk((f == 2) ? "R8 hour format" : "R8 field format", v, exp_t[f]);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule